// File: doc/BRIEF.md
# Open-Drain Clock/Data Line Pair Control Register

This block holds one 32-bit control word that owns two open-drain pad lines: a clock line and a data line. Software uses it to bit-bang a two-wire serial bus. Each line can be released, so that its external pull-up takes it high, or driven low. The sampled level on each pad can always be read back.

Every writable line field has a companion enable bit in the same write word. A field changes only when its enable bit is set in that write. Software can therefore move one line, or only the direction of a line, without first reading the register. The enable bits are never stored.

The pad inputs pass through a two-stage synchronizer before they appear in the read word. The sampled level is shown whether the line is released or driven, so software can detect another device holding the line low.

Top module: `odg_pair_ctrl`

## Requirements
- R1: After reset both lines are inputs (pad output enable 0), their stored output level is 0, both pull-ups are enabled, and both sampled-input bits read 1.
- R2: The direction bit (bit 0 for the clock line, bit 16 for the data line; 1 = drive) takes the written value only when its enable bit (bit 1 / bit 17) is 1 in the same write; otherwise it keeps its value.
- R3: The output-level bit (bit 2 / bit 18) takes the written value only when its enable bit (bit 3 / bit 19) is 1 in the same write; otherwise it keeps its value.
- R4: The enable bits (1, 3, 17, 19) always read back as 0.
- R5: The pull-up disable bits (bit 5 / bit 21) are loaded by every write with no enable bit. The pad pull-up enable output is the inverse of the stored bit.
- R6: Each line's pad output enable equals its stored direction bit, and its pad output level equals its stored output-level bit.
- R7: Each sampled-input bit (bit 4 / bit 20) shows the pad level captured two rising clock edges earlier.
- R8: The sampled-input bit follows the pad even while the line is driven.
- R9: A write whose enable bits for one line are all clear leaves that line's direction and level unchanged, whatever the other line's fields do.
- R10: Bits 6..15 and 22..31, and writes to the sampled-input bits, have no effect: those bits read 0 and the input bits show only the pad.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write word: fields plus their enable bits |
| rd_data | output | 32 | Current register contents |
| ck_pad_in | input | 1 | Clock line pad level |
| dt_pad_in | input | 1 | Data line pad level |
| ck_oe | output | 1 | Clock line pad output enable |
| ck_out | output | 1 | Clock line pad output level |
| ck_pu_en | output | 1 | Clock line pull-up enable |
| dt_oe | output | 1 | Data line pad output enable |
| dt_out | output | 1 | Data line pad output level |
| dt_pu_en | output | 1 | Data line pull-up enable |

## Verification
The hardest case to reach is a sampled input that disagrees with the line's own drive: the line is driven low while the pad still reads high, or the reverse. This is the situation a bus-contention check in software depends on. The bench creates it by changing the pad inputs on their own schedule while the line is driven. It then reads the register on each of the next cycles to confirm the two-edge latency and that the drive does not mask the input. Streams of pseudo-random writes also mix set and clear enable bits across both lines, so that enable bits leaking between fields or lines show up.

// File: rtl/odg_pkg.sv
package odg_pkg;

    localparam int REG_W   = 32;
    localparam int N_LINES = 2;

    // Field offsets within one line's slice of the register word
    localparam int F_DIR    = 0;
    localparam int F_DIR_WE = 1;
    localparam int F_VAL    = 2;
    localparam int F_VAL_WE = 3;
    localparam int F_IN     = 4;
    localparam int F_PUD    = 5;
    localparam int FIELD_W  = 6;

    // Line index assignment
    localparam int LN_CK = 0;
    localparam int LN_DT = 1;

    typedef struct packed {
        logic dir;   // 1 = drive pad
        logic val;   // pad output level
        logic pud;   // pull-up disable
    } line_cfg_t;

    localparam line_cfg_t LINE_RST = '{dir: 1'b0, val: 1'b0, pud: 1'b0};

endpackage

// File: rtl/odg_sync.sv
module odg_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [STAGES-1:0] chain_d, chain_q;

    always_comb begin
        chain_d = {chain_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q <= {STAGES{RST_VAL}};
        else        chain_q <= chain_d;
    end

    assign dout = chain_q[STAGES-1];
endmodule

// File: rtl/odg_line.sv
module odg_line
    import odg_pkg::*;
#(
    parameter int   SYNC_STAGES = 2,
    parameter logic IN_RST      = 1'b1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [FIELD_W-1:0] wr_field,
    input  logic               pad_in,
    output logic               pad_oe,
    output logic               pad_out,
    output logic               pu_en,
    output logic [FIELD_W-1:0] rd_field
);
    line_cfg_t cfg_d, cfg_q;
    logic      in_sync;
    logic      unused_in_bit;

    assign unused_in_bit = wr_field[F_IN];

    odg_sync #(.STAGES(SYNC_STAGES), .RST_VAL(IN_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (pad_in),
        .dout (in_sync)
    );

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_field[F_DIR_WE]) cfg_d.dir = wr_field[F_DIR];
            if (wr_field[F_VAL_WE]) cfg_d.val = wr_field[F_VAL];
            cfg_d.pud = wr_field[F_PUD];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= LINE_RST;
        else        cfg_q <= cfg_d;
    end

    assign pad_oe  = cfg_q.dir;
    assign pad_out = cfg_q.val;
    assign pu_en   = ~cfg_q.pud;

    always_comb begin
        rd_field           = '0;
        rd_field[F_DIR]    = cfg_q.dir;
        rd_field[F_VAL]    = cfg_q.val;
        rd_field[F_IN]     = in_sync;
        rd_field[F_PUD]    = cfg_q.pud;
    end
endmodule

// File: rtl/odg_pair_ctrl.sv
module odg_pair_ctrl
    import odg_pkg::*;
#(
    parameter int   LINE_STRIDE = 16,
    parameter int   SYNC_STAGES = 2,
    parameter logic IN_RST      = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [REG_W-1:0] wr_data,
    output logic [REG_W-1:0] rd_data,
    input  logic             ck_pad_in,
    input  logic             dt_pad_in,
    output logic             ck_oe,
    output logic             ck_out,
    output logic             ck_pu_en,
    output logic             dt_oe,
    output logic             dt_out,
    output logic             dt_pu_en
);
    localparam int TOP_BIT = (N_LINES - 1) * LINE_STRIDE + FIELD_W;

    logic [N_LINES-1:0] pad_in_v, oe_v, out_v, pu_v;
    logic [FIELD_W-1:0] rd_field [N_LINES];
    logic [REG_W-1:0]   unused_wr_bits;

    assign unused_wr_bits = wr_data;

    assign pad_in_v[LN_CK] = ck_pad_in;
    assign pad_in_v[LN_DT] = dt_pad_in;

    generate
        for (genvar g = 0; g < N_LINES; g++) begin : g_line
            odg_line #(.SYNC_STAGES(SYNC_STAGES), .IN_RST(IN_RST)) u_line (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (wr_en),
                .wr_field(wr_data[g*LINE_STRIDE +: FIELD_W]),
                .pad_in  (pad_in_v[g]),
                .pad_oe  (oe_v[g]),
                .pad_out (out_v[g]),
                .pu_en   (pu_v[g]),
                .rd_field(rd_field[g])
            );
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int l = 0; l < N_LINES; l++) begin
            rd_data[l*LINE_STRIDE +: FIELD_W] = rd_field[l];
        end
    end

    assign ck_oe    = oe_v[LN_CK];
    assign ck_out   = out_v[LN_CK];
    assign ck_pu_en = pu_v[LN_CK];
    assign dt_oe    = oe_v[LN_DT];
    assign dt_out   = out_v[LN_DT];
    assign dt_pu_en = pu_v[LN_DT];

    initial begin
        if (TOP_BIT > REG_W || LINE_STRIDE < FIELD_W || SYNC_STAGES < 2)
            $error("odg_pair_ctrl: bad parameters");
    end
endmodule

// File: rtl/odg_chk.sv
module odg_chk
    import odg_pkg::*;
#(
    parameter int LINE_STRIDE = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [REG_W-1:0] wr_data,
    input logic [REG_W-1:0] rd_data,
    input logic             ck_pad_in,
    input logic             dt_pad_in,
    input logic             ck_oe,
    input logic             ck_out,
    input logic             ck_pu_en,
    input logic             dt_oe,
    input logic             dt_out,
    input logic             dt_pu_en
);
    localparam int D = LINE_STRIDE;

    logic [1:0] edges_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              edges_q <= '0;
        else if (edges_q != 2'd3) edges_q <= edges_q + 2'd1;
    end

    p_ck_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[F_DIR_WE]) |=> $stable(ck_oe));
    p_ck_dir_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[F_DIR_WE]) |=> ck_oe == $past(wr_data[F_DIR]));
    p_dt_dir_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[D+F_DIR_WE]) |=> $stable(dt_oe));
    p_ck_val_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_data[F_VAL_WE]) |=> $stable(ck_out));
    p_dt_val_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[D+F_VAL_WE]) |=> dt_out == $past(wr_data[D+F_VAL]));
    p_we_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[F_DIR_WE] == 1'b0 && rd_data[F_VAL_WE] == 1'b0 &&
        rd_data[D+F_DIR_WE] == 1'b0 && rd_data[D+F_VAL_WE] == 1'b0);
    p_pu_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> ck_pu_en == !$past(wr_data[F_PUD]) && dt_pu_en == !$past(wr_data[D+F_PUD]));
    p_oe_rd_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_data[F_DIR] == ck_oe && rd_data[D+F_DIR] == dt_oe);
    p_sync_ck_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q >= 2'd2) |-> rd_data[F_IN] == $past(ck_pad_in, 2));
    p_sync_dt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (edges_q >= 2'd2) |-> rd_data[D+F_IN] == $past(dt_pad_in, 2));
endmodule

bind odg_pair_ctrl odg_chk #(.LINE_STRIDE(LINE_STRIDE)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .ck_pad_in(ck_pad_in), .dt_pad_in(dt_pad_in),
    .ck_oe(ck_oe), .ck_out(ck_out), .ck_pu_en(ck_pu_en),
    .dt_oe(dt_oe), .dt_out(dt_out), .dt_pu_en(dt_pu_en)
);

// File: tb/sim_odg_pair_ctrl.sv
module sim_odg_pair_ctrl;
    // Bit positions taken from the requirements
    localparam int B_DIR = 0, B_DWE = 1, B_VAL = 2, B_VWE = 3, B_IN = 4, B_PUD = 5;
    localparam int STRIDE = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic [31:0] rd_data;
    logic        ck_pad_in = 1'b1, dt_pad_in = 1'b1;
    logic        ck_oe, ck_out, ck_pu_en, dt_oe, dt_out, dt_pu_en;

    int checks = 0;
    int errors = 0;

    // Behavioural model state
    bit m_dir [2];
    bit m_val [2];
    bit m_pud [2];
    bit pad_hist [2][$];

    always #10 clk = ~clk;

    odg_pair_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
        .ck_pad_in(ck_pad_in), .dt_pad_in(dt_pad_in),
        .ck_oe(ck_oe), .ck_out(ck_out), .ck_pu_en(ck_pu_en),
        .dt_oe(dt_oe), .dt_out(dt_out), .dt_pu_en(dt_pu_en)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic model_reset();
        for (int l = 0; l < 2; l++) begin
            m_dir[l] = 0; m_val[l] = 0; m_pud[l] = 0;
            pad_hist[l] = {1'b1, 1'b1};
        end
    endtask

    function automatic logic [31:0] exp_rd();
        logic [31:0] r = '0;
        for (int l = 0; l < 2; l++) begin
            r[l*STRIDE+B_DIR] = m_dir[l];
            r[l*STRIDE+B_VAL] = m_val[l];
            r[l*STRIDE+B_PUD] = m_pud[l];
            r[l*STRIDE+B_IN]  = pad_hist[l][0];
        end
        return r;
    endfunction

    task automatic compare_all();
        logic [31:0] e = exp_rd();
        logic [31:0] m;
        m = 32'h0005_0005;
        chk((rd_data & m) == (e & m), "R2/R3 stored dir+level", rd_data & m, e & m);
        m = 32'h000A_000A;
        chk((rd_data & m) == 0, "R4 enable bits read 0", rd_data & m, 0);
        m = 32'h0010_0010;
        chk((rd_data & m) == (e & m), "R7 sampled input", rd_data & m, e & m);
        m = 32'h0020_0020;
        chk((rd_data & m) == (e & m), "R5 pull-up disable", rd_data & m, e & m);
        m = 32'hFFC0_FFC0;
        chk((rd_data & m) == 0, "R10 unused bits", rd_data & m, 0);
        chk({ck_oe, ck_out, dt_oe, dt_out} == {m_dir[0], m_val[0], m_dir[1], m_val[1]},
            "R6 pad oe/out", {ck_oe, ck_out, dt_oe, dt_out}, {m_dir[0], m_val[0], m_dir[1], m_val[1]});
        chk({ck_pu_en, dt_pu_en} == {!m_pud[0], !m_pud[1]}, "R5 pull-up enable",
            {ck_pu_en, dt_pu_en}, {!m_pud[0], !m_pud[1]});
    endtask

    task automatic step(input bit we, input logic [31:0] d, input bit pc, input bit pd);
        bit pads [2];
        @(negedge clk);
        wr_en = we; wr_data = d; ck_pad_in = pc; dt_pad_in = pd;
        pads[0] = pc; pads[1] = pd;
        @(posedge clk);
        for (int l = 0; l < 2; l++) begin
            if (we) begin
                if (d[l*STRIDE+B_DWE]) m_dir[l] = d[l*STRIDE+B_DIR];
                if (d[l*STRIDE+B_VWE]) m_val[l] = d[l*STRIDE+B_VAL];
                m_pud[l] = d[l*STRIDE+B_PUD];
            end
            pad_hist[l].push_back(pads[l]);
            while (pad_hist[l].size() > 2) void'(pad_hist[l].pop_front());
        end
        #5;
        compare_all();
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [31:0] lfsr;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk({ck_oe, ck_out, dt_oe, dt_out} == 4'b0000, "R1 lines released", {ck_oe, ck_out, dt_oe, dt_out}, 0);
        chk({ck_pu_en, dt_pu_en} == 2'b11, "R1 pull-ups on", {ck_pu_en, dt_pu_en}, 2'b11);
        chk(rd_data == 32'h0010_0010, "R1 reset read word", rd_data, 32'h0010_0010);

        // R2: drive clock line; data-line dir bit without enable ignored
        step(1, 32'h0000_0003, 1, 1);
        step(1, 32'h0001_0000, 1, 1);
        chk(dt_oe == 1'b0, "R2 dir without enable", dt_oe, 0);
        // R3: level with and without enable
        step(1, 32'h0000_000C, 1, 1);
        step(1, 32'h0000_0004, 1, 1);
        step(1, 32'h0000_0008, 1, 1);
        chk(ck_out == 1'b0, "R3 level cleared with enable", ck_out, 0);
        // R9: drive data line low with clock-line enables clear
        step(1, 32'h000B_0000, 1, 1);
        chk(ck_oe == 1'b1 && dt_oe == 1'b1, "R9 clock line untouched", {ck_oe, dt_oe}, 2'b11);
        // R7/R8: pad low while driven, then contention high while driven
        step(0, 0, 1, 0);
        chk(rd_data[STRIDE+B_IN] == 1'b1, "R7 one edge not yet visible", rd_data[STRIDE+B_IN], 1);
        step(0, 0, 1, 0);
        chk(rd_data[STRIDE+B_IN] == 1'b0, "R7 visible after two edges", rd_data[STRIDE+B_IN], 0);
        step(0, 0, 1, 1);
        step(0, 0, 1, 1);
        chk(rd_data[STRIDE+B_IN] == 1'b1 && dt_oe == 1'b1, "R8 input seen while driven",
            {dt_oe, rd_data[STRIDE+B_IN]}, 2'b11);
        // R5: pull-up disables loaded by plain writes
        step(1, 32'h0020_0020, 1, 1);
        chk({ck_pu_en, dt_pu_en} == 2'b00, "R5 pull-ups off", {ck_pu_en, dt_pu_en}, 0);
        step(1, 32'h0000_0000, 1, 1);
        chk({ck_pu_en, dt_pu_en, ck_oe, dt_oe} == 4'b1111, "R5 pull-ups back, R9 lines held",
            {ck_pu_en, dt_pu_en, ck_oe, dt_oe}, 4'b1111);
        // R10/R4: all ones, including input bits
        step(1, 32'hFFFF_FFFF, 0, 0);
        step(0, 0, 0, 0);
        step(0, 0, 0, 0);
        chk(rd_data == 32'h0025_0025, "R10 all-ones write", rd_data, 32'h0025_0025);
        // Release sequence: dir input with enable, then empty write, then read pad
        step(1, 32'h0002_0002, 1, 0);
        step(1, 32'h0000_0000, 1, 0);
        step(0, 0, 1, 0);
        chk(ck_oe == 0 && dt_oe == 0 && rd_data[B_IN] == 1 && rd_data[STRIDE+B_IN] == 0,
            "R2 release then read pad", {ck_oe, dt_oe, rd_data[B_IN], rd_data[STRIDE+B_IN]}, 4'b0010);

        // Pseudo-random mixed writes and pad activity
        lfsr = 32'hACE1_2468;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
            step(lfsr[7], lfsr ^ {lfsr[15:0], lfsr[31:16]}, lfsr[9], lfsr[12]);
        end

        // Reset mid-run returns to R1 state
        @(negedge clk); rst_n = 1'b0; model_reset();
        @(negedge clk); rst_n = 1'b1; #1;
        chk(rd_data == 32'h0010_0010 && {ck_oe, dt_oe} == 0, "R1 reset after activity", rd_data, 32'h0010_0010);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule